// File: doc/BRIEF.md
# Multichannel TDM Serial Port

This block is a full-duplex serial port for time-division multiplexed links. A single-cycle frame sync pulse aligns a slot counter. Each frame is then cut into equal slots of `SLOT_W` bit clocks. The frame holds either a short or a long count of slots, chosen by one configuration pin. The receive line and the transmit line share the bit clock and the frame sync, and both run at the same time.

Each direction has its own channel enable mask. Software writes each mask as a pair of 16-bit halves. Bit n of a mask belongs to channel n, which is time slot n. On receive, the port assembles each enabled slot into a parallel word and hands it out with its channel number. Disabled slots are dropped without trace. On transmit, the port asks for the word of the next enabled slot one slot early, shifts it out MSB first, and raises an output enable while it drives. A disabled slot leaves the line undriven. So does a slot whose word never arrived, and that case also sets a sticky underrun flag.

The bit clock is the block clock (`clk`). Serial data is sampled and launched on its rising edge.

Top module: `tdm_sport`

## Requirements
- R1: `fsync_i` sampled high at a rising edge makes the next cycle bit 0 of slot 0. Slots are 16 bits wide, each data word travels MSB first, and a frame sync that arrives at any time realigns the count.
- R2: With `frame_long_i`=1 a frame has 32 slots, and with `frame_long_i`=0 it has 24 slots. After the last slot the counter wraps to slot 0 without a new sync, and mask bits 24..31 have no effect in the 24-slot mode.
- R3: A write with `mask_we_i`=1 loads `mask_wdata_i` into the register chosen by `mask_sel_i`. The encodings are 0 = receive channels 0..15, 1 = receive channels 16..31, 2 = transmit channels 0..15 and 3 = transmit channels 16..31. Bit k of a register enables channel (16·half + k). All masks reset to zero.
- R4: For each enabled receive slot, `rx_valid_o` is high for exactly one cycle, the cycle after the slot's last bit. In that cycle `rx_data_o` holds the 16 bits received and `rx_chan_o` holds the slot number. A disabled slot produces no pulse.
- R5: An enabled transmit slot whose word was written in time drives that word on `sd_o` MSB first, with `sd_oe_o`=1 for all 16 cycles of the slot.
- R6: During bit 1 of every slot, `tx_req_o` pulses for one cycle if the following slot (wrapping to 0 after the last slot) is enabled for transmit. `tx_req_chan_o` then gives that slot. A word written with `tx_wr_i` before the slot starts is sent in it.
- R7: A transmit slot whose mask bit is clear keeps `sd_oe_o`=0 and `sd_o`=0 for the whole slot.
- R8: An enabled transmit slot that starts with no word written drives `sd_o`=0 with `sd_oe_o`=0 and sets `underrun_o`. `underrun_o` stays set until `underrun_clr_i` is pulsed.
- R9: While reset is applied, and after it is released, `rx_valid_o`, `tx_req_o`, `sd_o`, `sd_oe_o` and `underrun_o` are 0.
- R10: Receive and transmit masks are independent. A receive mask of 0x0007 in the low half and 0x0007 in the high half delivers exactly channels 0, 1, 2, 16, 17 and 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync, one cycle before bit 0 of slot 0 |
| sd_i | input | 1 | Serial receive data |
| sd_o | output | 1 | Serial transmit data |
| sd_oe_o | output | 1 | Transmit output enable |
| frame_long_i | input | 1 | 1 = 32 slots per frame, 0 = 24 slots |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_sel_i | input | 2 | Mask register select |
| mask_wdata_i | input | 16 | Mask register write data |
| rx_valid_o | output | 1 | Received word strobe |
| rx_data_o | output | 16 | Received word |
| rx_chan_o | output | 5 | Channel of the received word |
| tx_req_o | output | 1 | Transmit word request |
| tx_req_chan_o | output | 5 | Channel being requested |
| tx_wr_i | input | 1 | Transmit word write strobe |
| tx_data_i | input | 16 | Transmit word |
| underrun_o | output | 1 | Sticky transmit underrun flag |
| underrun_clr_i | input | 1 | Clears the underrun flag |

## Verification
The bench builds the port with its default parameters: 16-bit slots, a 32-slot long frame, a 24-slot short frame and two 16-bit mask halves per direction. With these values both frame lengths can be reached. The bench runs back-to-back synced long frames, with the receive mask set to 0x0007/0x0007 and a different transmit mask. It also runs a short frame that wraps into the next frame with no sync, while high receive mask bits that lie past slot 23 are set, and it withholds one transmit word so that an underrun occurs in the last slots of the short frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  // Direction selector, taken from the top bit of the mask register select
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } tdm_dir_e;

  localparam int unsigned TDM_SLOT_W_DEF      = 16;
  localparam int unsigned TDM_MAX_SLOTS_DEF   = 32;
  localparam int unsigned TDM_SHORT_SLOTS_DEF = 24;
  localparam int unsigned TDM_MASK_REG_W_DEF  = 16;

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter  int unsigned SLOT_W      = 16,
  parameter  int unsigned MAX_SLOTS   = 32,
  parameter  int unsigned SHORT_SLOTS = 24,
  localparam int unsigned BIT_W       = $clog2(SLOT_W),
  localparam int unsigned CHAN_W      = $clog2(MAX_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic              frame_long_i,
  output logic              active_o,
  output logic [CHAN_W-1:0] slot_o,
  output logic              first_bit_o,
  output logic              last_bit_o,
  output logic              load_o,
  output logic [CHAN_W-1:0] load_slot_o,
  output logic [CHAN_W-1:0] after_slot_o
);

  localparam logic [BIT_W-1:0]  BIT_LAST   = BIT_W'(SLOT_W - 1);
  localparam logic [CHAN_W-1:0] LAST_LONG  = CHAN_W'(MAX_SLOTS - 1);
  localparam logic [CHAN_W-1:0] LAST_SHORT = CHAN_W'(SHORT_SLOTS - 1);

  logic              active_q, active_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [CHAN_W-1:0] slot_q, slot_d;
  logic [CHAN_W-1:0] last_slot;
  logic [CHAN_W-1:0] succ;
  logic              at_last_bit;

  // Decode of the current position
  always_comb begin
    last_slot   = frame_long_i ? LAST_LONG : LAST_SHORT;
    succ        = (slot_q >= last_slot) ? '0 : slot_q + CHAN_W'(1);
    at_last_bit = active_q && (bit_q == BIT_LAST);
  end

  // Next state
  always_comb begin
    active_d = active_q;
    bit_d    = bit_q;
    slot_d   = slot_q;
    if (fsync_i) begin
      active_d = 1'b1;
      bit_d    = '0;
      slot_d   = '0;
    end else if (active_q) begin
      if (at_last_bit) begin
        bit_d  = '0;
        slot_d = succ;
      end else begin
        bit_d  = bit_q + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      slot_q   <= '0;
    end else begin
      active_q <= active_d;
      bit_q    <= bit_d;
      slot_q   <= slot_d;
    end
  end

  assign active_o     = active_q;
  assign slot_o       = slot_q;
  assign first_bit_o  = active_q && (bit_q == '0);
  assign last_bit_o   = at_last_bit;
  assign load_o       = fsync_i || at_last_bit;
  assign load_slot_o  = fsync_i ? '0 : succ;
  assign after_slot_o = succ;

endmodule

// File: rtl/tdm_mask_bank.sv
module tdm_mask_bank #(
  parameter  int unsigned REG_W    = 16,
  parameter  int unsigned NUM_REGS = 2,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned SEL_W    = IDX_W + 1,
  localparam int unsigned MASK_W   = REG_W * NUM_REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [MASK_W-1:0] rx_mask_o,
  output logic [MASK_W-1:0] tx_mask_o
);

  wire [1:0][MASK_W-1:0] dir_mask;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [REG_W-1:0] seg_q;
      logic [REG_W-1:0] seg_d;
      logic             hit;

      assign hit = we_i
                && (sel_i[SEL_W-1] == ((d == 1) ? tdm_pkg::DIR_TX : tdm_pkg::DIR_RX))
                && (sel_i[IDX_W-1:0] == IDX_W'(r));

      always_comb begin
        seg_d = seg_q;
        if (hit) seg_d = wdata_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seg_q <= '0;
        else        seg_q <= seg_d;
      end

      assign dir_mask[d][r*REG_W +: REG_W] = seg_q;
    end
  end

  assign rx_mask_o = dir_mask[0];
  assign tx_mask_o = dir_mask[1];

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter  int unsigned SLOT_W    = 16,
  parameter  int unsigned MAX_SLOTS = 32,
  localparam int unsigned CHAN_W    = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sd_i,
  input  logic                 active_i,
  input  logic                 last_bit_i,
  input  logic [CHAN_W-1:0]    slot_i,
  input  logic [MAX_SLOTS-1:0] mask_i,
  output logic                 valid_o,
  output logic [SLOT_W-1:0]    data_o,
  output logic [CHAN_W-1:0]    chan_o
);

  logic [SLOT_W-1:0] sh_q, sh_d;
  logic [SLOT_W-1:0] data_q, data_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              valid_q, valid_d;
  logic              cap;

  always_comb begin
    sh_d    = active_i ? {sh_q[SLOT_W-2:0], sd_i} : sh_q;
    cap     = last_bit_i && mask_i[slot_i];
    valid_d = cap;
    data_d  = cap ? sh_d   : data_q;
    chan_d  = cap ? slot_i : chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      data_q  <= '0;
      chan_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      data_q  <= data_d;
      chan_q  <= chan_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign chan_o  = chan_q;

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
  parameter  int unsigned SLOT_W    = 16,
  parameter  int unsigned MAX_SLOTS = 32,
  localparam int unsigned CHAN_W    = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [CHAN_W-1:0]    load_slot_i,
  input  logic                 first_bit_i,
  input  logic [CHAN_W-1:0]    after_slot_i,
  input  logic [MAX_SLOTS-1:0] mask_i,
  input  logic                 wr_i,
  input  logic [SLOT_W-1:0]    wdata_i,
  input  logic                 under_clr_i,
  output logic                 sd_o,
  output logic                 oe_o,
  output logic                 req_o,
  output logic [CHAN_W-1:0]    req_chan_o,
  output logic                 underrun_o
);

  logic [SLOT_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic [SLOT_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              req_q, req_d;
  logic [CHAN_W-1:0] req_chan_q, req_chan_d;
  logic              under_q, under_d;
  logic              load_en, consume, starve;

  always_comb begin
    load_en = load_i && mask_i[load_slot_i];
    consume = load_en && full_q;
    starve  = load_en && !full_q;

    // Slot shifter: new word (or silence) at each slot boundary
    if (load_i) begin
      sh_d = consume ? hold_q : '0;
      oe_d = consume;
    end else begin
      sh_d = {sh_q[SLOT_W-2:0], 1'b0};
      oe_d = oe_q;
    end

    // Holding register: a write in the consume cycle refills it
    hold_d = wr_i ? wdata_i : hold_q;
    full_d = wr_i ? 1'b1 : (consume ? 1'b0 : full_q);

    // Request issued during bit 0, visible during bit 1
    req_d      = first_bit_i && mask_i[after_slot_i];
    req_chan_d = req_d ? after_slot_i : req_chan_q;

    under_d = starve ? 1'b1 : (under_clr_i ? 1'b0 : under_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      full_q     <= 1'b0;
      sh_q       <= '0;
      oe_q       <= 1'b0;
      req_q      <= 1'b0;
      req_chan_q <= '0;
      under_q    <= 1'b0;
    end else begin
      hold_q     <= hold_d;
      full_q     <= full_d;
      sh_q       <= sh_d;
      oe_q       <= oe_d;
      req_q      <= req_d;
      req_chan_q <= req_chan_d;
      under_q    <= under_d;
    end
  end

  assign sd_o       = sh_q[SLOT_W-1];
  assign oe_o       = oe_q;
  assign req_o      = req_q;
  assign req_chan_o = req_chan_q;
  assign underrun_o = under_q;

endmodule

// File: rtl/tdm_sport.sv
module tdm_sport #(
  parameter  int unsigned SLOT_W      = tdm_pkg::TDM_SLOT_W_DEF,
  parameter  int unsigned MAX_SLOTS   = tdm_pkg::TDM_MAX_SLOTS_DEF,
  parameter  int unsigned SHORT_SLOTS = tdm_pkg::TDM_SHORT_SLOTS_DEF,
  parameter  int unsigned MASK_REG_W  = tdm_pkg::TDM_MASK_REG_W_DEF,
  localparam int unsigned CHAN_W      = $clog2(MAX_SLOTS),
  localparam int unsigned NUM_MREGS   = MAX_SLOTS / MASK_REG_W,
  localparam int unsigned SEL_W       = $clog2(NUM_MREGS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic              frame_long_i,
  input  logic              mask_we_i,
  input  logic [SEL_W-1:0]  mask_sel_i,
  input  logic [MASK_REG_W-1:0] mask_wdata_i,
  output logic              rx_valid_o,
  output logic [SLOT_W-1:0] rx_data_o,
  output logic [CHAN_W-1:0] rx_chan_o,
  output logic              tx_req_o,
  output logic [CHAN_W-1:0] tx_req_chan_o,
  input  logic              tx_wr_i,
  input  logic [SLOT_W-1:0] tx_data_i,
  output logic              underrun_o,
  input  logic              underrun_clr_i
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [MAX_SLOTS-1:0] rx_mask_w;
  logic [MAX_SLOTS-1:0] tx_mask_w;
  logic                 active_w;
  logic [CHAN_W-1:0]    slot_w;
  logic                 first_bit_w;
  logic                 last_bit_w;
  logic                 load_w;
  logic [CHAN_W-1:0]    load_slot_w;
  logic [CHAN_W-1:0]    after_slot_w;

  tdm_slot_timer #(
    .SLOT_W      (SLOT_W),
    .MAX_SLOTS   (MAX_SLOTS),
    .SHORT_SLOTS (SHORT_SLOTS)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .fsync_i      (fsync_i),
    .frame_long_i (frame_long_i),
    .active_o     (active_w),
    .slot_o       (slot_w),
    .first_bit_o  (first_bit_w),
    .last_bit_o   (last_bit_w),
    .load_o       (load_w),
    .load_slot_o  (load_slot_w),
    .after_slot_o (after_slot_w)
  );

  tdm_mask_bank #(
    .REG_W    (MASK_REG_W),
    .NUM_REGS (NUM_MREGS)
  ) u_masks (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .we_i      (mask_we_i),
    .sel_i     (mask_sel_i),
    .wdata_i   (mask_wdata_i),
    .rx_mask_o (rx_mask_w),
    .tx_mask_o (tx_mask_w)
  );

  tdm_rx_deser #(
    .SLOT_W    (SLOT_W),
    .MAX_SLOTS (MAX_SLOTS)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .sd_i       (sd_i),
    .active_i   (active_w),
    .last_bit_i (last_bit_w),
    .slot_i     (slot_w),
    .mask_i     (rx_mask_w),
    .valid_o    (rx_valid_o),
    .data_o     (rx_data_o),
    .chan_o     (rx_chan_o)
  );

  tdm_tx_ser #(
    .SLOT_W    (SLOT_W),
    .MAX_SLOTS (MAX_SLOTS)
  ) u_tx (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .load_i       (load_w),
    .load_slot_i  (load_slot_w),
    .first_bit_i  (first_bit_w),
    .after_slot_i (after_slot_w),
    .mask_i       (tx_mask_w),
    .wr_i         (tx_wr_i),
    .wdata_i      (tx_data_i),
    .under_clr_i  (underrun_clr_i),
    .sd_o         (sd_o),
    .oe_o         (sd_oe_o),
    .req_o        (tx_req_o),
    .req_chan_o   (tx_req_chan_o),
    .underrun_o   (underrun_o)
  );

endmodule

// File: rtl/tdm_sport_chk.sv
module tdm_sport_chk #(
  parameter  int unsigned MAX_SLOTS   = 32,
  parameter  int unsigned SHORT_SLOTS = 24,
  localparam int unsigned CHAN_W      = $clog2(MAX_SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_long_i,
  input logic                 rx_valid_o,
  input logic [CHAN_W-1:0]    rx_chan_o,
  input logic [MAX_SLOTS-1:0] rx_mask,
  input logic                 tx_req_o,
  input logic [CHAN_W-1:0]    tx_req_chan_o,
  input logic [MAX_SLOTS-1:0] tx_mask,
  input logic                 sd_o,
  input logic                 sd_oe_o,
  input logic                 underrun_o,
  input logic                 underrun_clr_i
);

  // R4
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R4
  rx_enabled_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> rx_mask[rx_chan_o]);

  // R2
  rx_chan_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (frame_long_i || (rx_chan_o < CHAN_W'(SHORT_SLOTS))));

  // R7
  tx_quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe_o |-> !sd_o);

  // R6
  tx_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |=> !tx_req_o);

  // R6
  tx_req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |-> tx_mask[tx_req_chan_o]);

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_o && !underrun_clr_i) |=> underrun_o);

endmodule

bind tdm_sport tdm_sport_chk #(
  .MAX_SLOTS   (MAX_SLOTS),
  .SHORT_SLOTS (SHORT_SLOTS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_long_i   (frame_long_i),
  .rx_valid_o     (rx_valid_o),
  .rx_chan_o      (rx_chan_o),
  .rx_mask        (rx_mask_w),
  .tx_req_o       (tx_req_o),
  .tx_req_chan_o  (tx_req_chan_o),
  .tx_mask        (tx_mask_w),
  .sd_o           (sd_o),
  .sd_oe_o        (sd_oe_o),
  .underrun_o     (underrun_o),
  .underrun_clr_i (underrun_clr_i)
);

// File: tb/tdm_sport_bench.sv
module tdm_sport_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync_i = 1'b0;
  logic        sd_i = 1'b0;
  logic        sd_o;
  logic        sd_oe_o;
  logic        frame_long_i = 1'b1;
  logic        mask_we_i = 1'b0;
  logic [1:0]  mask_sel_i = 2'd0;
  logic [15:0] mask_wdata_i = 16'h0;
  logic        rx_valid_o;
  logic [15:0] rx_data_o;
  logic [4:0]  rx_chan_o;
  logic        tx_req_o;
  logic [4:0]  tx_req_chan_o;
  logic        tx_wr_i = 1'b0;
  logic [15:0] tx_data_i = 16'h0;
  logic        underrun_o;
  logic        underrun_clr_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;
  logic [20:0] exp_q[$];

  always #10 clk = ~clk;

  tdm_sport u_tdm_sport (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .sd_i(sd_i),
    .sd_o(sd_o), .sd_oe_o(sd_oe_o), .frame_long_i(frame_long_i),
    .mask_we_i(mask_we_i), .mask_sel_i(mask_sel_i), .mask_wdata_i(mask_wdata_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_chan_o(rx_chan_o),
    .tx_req_o(tx_req_o), .tx_req_chan_o(tx_req_chan_o),
    .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i),
    .underrun_o(underrun_o), .underrun_clr_i(underrun_clr_i)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rxw(int s, int f);
    return 16'h9C35 ^ 16'(s * 16'h0211) ^ 16'(f * 16'h4105);
  endfunction

  function automatic logic [15:0] txw(int s, int f);
    return 16'h5AC3 ^ 16'(s * 16'h0307) ^ 16'(f * 16'h1090);
  endfunction

  task automatic do_reset(bit long_mode);
    rst_n = 1'b0;
    mon_on = 1'b0;
    repeat (3) @(negedge clk);
    frame_long_i = long_mode;
    // R9: outputs quiet while reset is held
    chk({rx_valid_o, tx_req_o, sd_o, sd_oe_o, underrun_o} == 5'b0, "R9", "outputs in reset",
        32'({rx_valid_o, tx_req_o, sd_o, sd_oe_o, underrun_o}), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({rx_valid_o, tx_req_o, sd_o, sd_oe_o, underrun_o} == 5'b0, "R9", "outputs after reset",
        32'({rx_valid_o, tx_req_o, sd_o, sd_oe_o, underrun_o}), 32'h0);
    mon_on = 1'b1;
  endtask

  // R3: select 0 rx low, 1 rx high, 2 tx low, 3 tx high
  task automatic wr_mask(logic [1:0] sel, logic [15:0] val);
    @(negedge clk);
    mask_we_i = 1'b1; mask_sel_i = sel; mask_wdata_i = val;
    @(negedge clk);
    mask_we_i = 1'b0;
  endtask

  // Drives whole slots, pushes expected receive words, checks transmit per slot
  task automatic run_slots(int nslots, int total_slots, bit sync_each, int skip_slot,
                           logic [31:0] rxm, logic [31:0] txm);
    bit tx_bad;
    bit req_bad;
    if (txm[0]) begin
      @(negedge clk);
      tx_wr_i = 1'b1; tx_data_i = txw(0, 0);
      @(negedge clk);
      tx_wr_i = 1'b0;
    end
    @(negedge clk);
    fsync_i = 1'b1;
    tx_bad = 1'b0;
    req_bad = 1'b0;
    for (int c = 0; c < total_slots * 16; c++) begin
      int sa, sl, fr, b, na, nsl, nfr;
      logic [15:0] rword, tword;
      logic exp_oe, exp_bit, exp_req;
      @(negedge clk);
      sa = c / 16; sl = sa % nslots; fr = sa / nslots; b = c % 16;
      na = sa + 1; nsl = na % nslots; nfr = na / nslots;
      fsync_i = 1'b0;
      tx_wr_i = 1'b0;
      if (sync_each && b == 15 && sl == nslots - 1 && c != total_slots * 16 - 1)
        fsync_i = 1'b1;
      rword = rxw(sl, fr);
      sd_i = rword[15 - b];
      if (b == 15 && rxm[sl]) exp_q.push_back({5'(sl), rword});
      tword   = txw(sl, fr);
      exp_oe  = txm[sl] && (sl != skip_slot);
      exp_bit = exp_oe ? tword[15 - b] : 1'b0;
      if (b == 0) begin tx_bad = 1'b0; req_bad = 1'b0; end
      if (sd_oe_o !== exp_oe || sd_o !== exp_bit) tx_bad = 1'b1;
      exp_req = (b == 1) && txm[nsl];
      if (tx_req_o !== exp_req || (exp_req && tx_req_chan_o !== 5'(nsl))) req_bad = 1'b1;
      if (exp_req && nsl != skip_slot) begin
        tx_wr_i = 1'b1;
        tx_data_i = txw(nsl, nfr);
      end
      if (b == 15) begin
        chk(!tx_bad, exp_oe ? "R5" : (txm[sl] ? "R8" : "R7"), $sformatf("tx slot %0d", sl),
            32'(tx_bad), 32'h0);
        chk(!req_bad, "R6", $sformatf("request ahead of slot %0d", nsl), 32'(req_bad), 32'h0);
      end
    end
    @(negedge clk);
    fsync_i = 1'b0;
    tx_wr_i = 1'b0;
  endtask

  // Scoreboard monitor: pops one expected word per receive strobe
  always @(negedge clk) begin
    if (mon_on && rx_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected rx word on channel", 32'(rx_chan_o), 32'hFFFF_FFFF);
      end else begin
        logic [20:0] e;
        e = exp_q.pop_front();
        chk({rx_chan_o, rx_data_o} == e, "R1 R4 R10", "rx channel/word",
            32'({rx_chan_o, rx_data_o}), 32'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // Long frames, rx 0x0007/0x0007 (R10), different tx mask
    do_reset(1'b1);
    wr_mask(2'd0, 16'h0007);
    wr_mask(2'd1, 16'h0007);
    wr_mask(2'd2, 16'h8005);
    wr_mask(2'd3, 16'h0002);
    run_slots(32, 64, 1'b1, -1, 32'h0007_0007, 32'h0002_8005);
    chk(underrun_o == 1'b0, "R8", "no underrun when fed", 32'(underrun_o), 32'h0);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R4 R10", "rx words outstanding", 32'(exp_q.size()), 32'h0);

    // Short frames wrapping without sync (R2), one starved slot (R8)
    do_reset(1'b0);
    wr_mask(2'd0, 16'h0001);
    wr_mask(2'd1, 16'hFF80);
    wr_mask(2'd2, 16'h0001);
    wr_mask(2'd3, 16'h00C0);
    run_slots(24, 26, 1'b0, 22, 32'hFF80_0001, 32'h00C0_0001);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 R4", "rx words outstanding", 32'(exp_q.size()), 32'h0);
    chk(underrun_o == 1'b1, "R8", "underrun flag set", 32'(underrun_o), 32'h1);
    @(negedge clk);
    chk(underrun_o == 1'b1, "R8", "underrun flag held", 32'(underrun_o), 32'h1);
    underrun_clr_i = 1'b1;
    @(negedge clk);
    underrun_clr_i = 1'b0;
    chk(underrun_o == 1'b0, "R8", "underrun flag cleared", 32'(underrun_o), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule